// File: doc/BRIEF.md
# Pre/Post-Trigger Capture Sequencer

This block decides which samples of a monitored bus are kept around a trigger event. Once it is armed, every sample goes into a circular buffer, so the most recent samples before the trigger are always on hand. When the trigger fires, a programmed number of further samples is recorded and the capture closes. The result is a window of the form "pre samples, the trigger sample, post samples". If the trigger fires before the pre-trigger region has filled, the block still takes it and reports how many pre-trigger samples it actually kept.

A run can hold several captures back to back. Each capture has its own memory bank and its own index. As soon as one capture closes, the next one starts filling on the very next cycle, so two events that come close together are both recorded. The block also drives a reset-hold line to the logic being observed. This line keeps that logic in reset until the first start command. It drops on the same clock edge at which sampling begins, so the first cycles after reset release are captured.

The trigger source is assumed to need a fixed pipeline latency. The sample stream is delayed by the same number of cycles, so the latched trigger position lines up with the sample that caused the trigger. After the run, a read port returns the stored windows in time order, capture 0 first.

Top module: `trace_window_seq`

## Requirements
- R1: While reset is asserted and after it, `phase` is 0 (idle), `rd_valid` is 0, and `dut_hold` equals `cfg_hold_en`.
- R2: A `cmd_start` pulse seen in idle moves `phase` to 1 (filling) at that edge. In any other phase, `cmd_start` is ignored. A `cmd_stop` pulse seen in phases 1, 2 or 3 returns `phase` to 0 at that edge and throws the capture away, so a later `rd_en` produces no `rd_valid`.
- R3: A `trig_in` pulse seen at edge n refers to the sample presented on `smp_data` at edge n-TRIG_LAT. That sample appears in the readout at position `rd_pre` of its window.
- R4: Once `cfg_pre` samples have been stored in the current capture, `phase` becomes 2 (waiting for trigger). With `cfg_pre` = 0, this happens after the first stored sample.
- R5: A trigger taken while filling keeps only the samples stored so far. The reported pre-trigger count is the smaller of that number and `cfg_pre`.
- R6: After the trigger sample, exactly `cfg_post` more samples are stored while `phase` is 3 (post-trigger). `trig_in` is ignored during this phase. With `cfg_post` = 0, the capture closes at the trigger edge.
- R7: A run holds `cfg_seq_last`+1 captures. When a capture that is not the last one closes, `cap_idx` increments and `phase` returns to 1 at that same edge, and storing continues on the next cycle.
- R8: After the last capture closes, `phase` is 4 (done). Each edge with `rd_en` high in phase 4 or 5 (reading) returns one stored sample one cycle later on `rd_data` with `rd_valid`. Samples come in time order, capture 0 first. `rd_last` marks the final sample, after which `phase` is 0. `rd_en` has no effect in any other phase.
- R9: The buffer is circular with DEPTH entries per capture. A window is read back correctly even after the write position has wrapped many times.
- R10: `dut_hold` stays high from reset until the edge that accepts the first start command. It falls at that edge and stays low until the next reset.
- R11: Each read sample carries `rd_cap`, the index of its capture, and `rd_pre`, that capture's actual pre-trigger count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Arm pulse |
| cmd_stop | input | 1 | Abort pulse |
| cfg_pre | input | AW | Pre-trigger sample count (cfg_pre + cfg_post < DEPTH) |
| cfg_post | input | AW | Post-trigger sample count |
| cfg_seq_last | input | SQW | Number of captures in a run minus one |
| cfg_hold_en | input | 1 | Enables the reset-hold line |
| smp_data | input | SAMPLE_W | Monitored sample vector |
| trig_in | input | 1 | Trigger, TRIG_LAT cycles after its sample |
| rd_en | input | 1 | Read one stored sample |
| phase | output | 3 | 0 idle, 1 filling, 2 waiting, 3 post, 4 done, 5 reading |
| cap_idx | output | SQW | Index of the capture being recorded |
| dut_hold | output | 1 | Reset hold to the observed logic |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | SAMPLE_W | Read sample |
| rd_cap | output | SQW | Capture index of the read sample |
| rd_pre | output | AW | Actual pre-trigger count of that capture |
| rd_last | output | 1 | Final sample of the run |

## Verification
Phase changes caused by commands, stored samples, triggers and post-count completion all appear after the clock edge that sees the cause. The bench therefore drives on the falling edge and checks `phase`, `cap_idx` and `dut_hold` on the following falling edge, using an edge counter to pick the exact cycle. A trigger is driven TRIG_LAT edges after the edge that presented its sample. Read data arrives one edge after each `rd_en` edge. The bench's monitor compares every `rd_valid` item on the falling edge against a queue that the driver filled in time order, and it counts any item that arrives when nothing was expected as a failure.

// File: rtl/tws_pkg.sv
package tws_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_FILL = 3'd1,
      PH_WAIT = 3'd2,
      PH_POST = 3'd3,
      PH_DONE = 3'd4,
      PH_READ = 3'd5
   } phase_e;
endpackage

// File: rtl/tws_delay.sv
module tws_delay #(
   parameter int W   = 8,
   parameter int LAT = 2
) (
   input  logic         clk,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (LAT == 0) begin : g_pass
         assign q = d;
      end else begin : g_pipe
         logic [W-1:0] stg [LAT];
         always_ff @(posedge clk) stg[0] <= d;
         for (genvar i = 1; i < LAT; i++) begin : g_stage
            always_ff @(posedge clk) stg[i] <= stg[i-1];
         end
         assign q = stg[LAT-1];
      end
   endgenerate
endmodule

// File: rtl/tws_mem.sv
module tws_mem #(
   parameter int W  = 8,
   parameter int MW = 6,
   localparam int ENTRIES = 1 << MW
) (
   input  logic          clk,
   input  logic          we,
   input  logic [MW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic          re,
   input  logic [MW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] store [ENTRIES];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
      if (re) rdata <= store[raddr];
   end
endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
   import tws_pkg::*;
#(
   parameter int AW  = 4,
   parameter int SQW = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           stop,
   input  logic           trig,
   input  logic [AW-1:0]  cfg_pre,
   input  logic [AW-1:0]  cfg_post,
   input  logic [SQW-1:0] cfg_seq_last,
   input  logic           cfg_hold_en,
   input  logic           rd_go,
   input  logic           rd_finish,
   output phase_e         ph,
   output logic           wr_en,
   output logic [AW-1:0]  wr_ptr,
   output logic [SQW-1:0] cap_idx,
   output logic           cap_done,
   output logic [AW-1:0]  cap_trig_addr,
   output logic [AW-1:0]  cap_pre,
   output logic           arm_clr,
   output logic           dut_hold
);
   phase_e         ph_q;
   logic [AW-1:0]  wr_ptr_q, fill_q, post_q, taddr_q, pre_q;
   logic [SQW-1:0] cap_idx_q;
   logic           released_q;
   logic           armed, pre_side, trig_take, post_end, cap_end, more;

   always_comb begin
      armed     = (ph_q == PH_FILL) || (ph_q == PH_WAIT) || (ph_q == PH_POST);
      pre_side  = (ph_q == PH_FILL) || (ph_q == PH_WAIT);
      trig_take = pre_side && trig && !stop;
      post_end  = (ph_q == PH_POST) && !stop && (post_q == cfg_post - AW'(1));
      cap_end   = (trig_take && (cfg_post == '0)) || post_end;
      more      = (cap_idx_q != cfg_seq_last);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q       <= PH_IDLE;
         wr_ptr_q   <= '0;
         fill_q     <= '0;
         post_q     <= '0;
         taddr_q    <= '0;
         pre_q      <= '0;
         cap_idx_q  <= '0;
         released_q <= 1'b0;
      end else begin
         case (ph_q)
            PH_IDLE: begin
               if (start) begin
                  ph_q       <= PH_FILL;
                  wr_ptr_q   <= '0;
                  fill_q     <= '0;
                  cap_idx_q  <= '0;
                  released_q <= 1'b1;
               end
            end
            PH_FILL, PH_WAIT, PH_POST: begin
               if (stop) begin
                  ph_q <= PH_IDLE;
               end else begin
                  wr_ptr_q <= wr_ptr_q + AW'(1);
                  if (ph_q == PH_POST) begin
                     post_q <= post_q + AW'(1);
                  end else begin
                     if (fill_q < cfg_pre) fill_q <= fill_q + AW'(1);
                     if (trig_take) begin
                        taddr_q <= wr_ptr_q;
                        pre_q   <= fill_q;
                        post_q  <= '0;
                        ph_q    <= PH_POST;
                     end else if ((ph_q == PH_FILL) && ((fill_q + AW'(1)) >= cfg_pre)) begin
                        ph_q <= PH_WAIT;
                     end
                  end
                  if (cap_end) begin
                     if (more) begin
                        ph_q      <= PH_FILL;
                        cap_idx_q <= cap_idx_q + SQW'(1);
                        wr_ptr_q  <= '0;
                        fill_q    <= '0;
                     end else begin
                        ph_q <= PH_DONE;
                     end
                  end
               end
            end
            PH_DONE: if (rd_go) ph_q <= rd_finish ? PH_IDLE : PH_READ;
            PH_READ: if (rd_finish) ph_q <= PH_IDLE;
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign ph            = ph_q;
   assign wr_en         = armed;
   assign wr_ptr        = wr_ptr_q;
   assign cap_idx       = cap_idx_q;
   assign cap_done      = cap_end;
   assign cap_trig_addr = trig_take ? wr_ptr_q : taddr_q;
   assign cap_pre       = trig_take ? fill_q : pre_q;
   assign arm_clr       = (ph_q == PH_IDLE) && start;
   assign dut_hold      = cfg_hold_en && !released_q;

   AST_HOLD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      dut_hold |-> (ph_q == PH_IDLE)); // R10
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !stop && !cap_done) |=> (wr_ptr_q == $past(wr_ptr_q) + AW'(1))); // R9
   AST_PRE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cap_done |-> (cap_pre <= cfg_pre)); // R5
   AST_POST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_POST) |-> (post_q < cfg_post)); // R6
   AST_SEQ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (cap_idx_q <= cfg_seq_last)); // R7
endmodule

// File: rtl/tws_reader.sv
module tws_reader #(
   parameter int AW  = 4,
   parameter int SQW = 2,
   localparam int NCAP = 1 << SQW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           cap_done,
   input  logic [SQW-1:0] cap_idx,
   input  logic [AW-1:0]  cap_trig_addr,
   input  logic [AW-1:0]  cap_pre,
   input  logic [AW-1:0]  cfg_post,
   input  logic [SQW-1:0] cfg_seq_last,
   input  logic           rd_go,
   output logic           rd_finish,
   output logic [SQW-1:0] rd_bank,
   output logic [AW-1:0]  rd_addr,
   output logic           rd_valid,
   output logic [SQW-1:0] rd_cap,
   output logic [AW-1:0]  rd_pre,
   output logic           rd_last
);
   logic [AW-1:0]  trig_tab [NCAP];
   logic [AW-1:0]  pre_tab  [NCAP];
   logic [SQW-1:0] cap_q;
   logic [AW-1:0]  off_q;
   logic [AW-1:0]  cur_trig, cur_pre, span;
   logic           off_last, cap_last;

   always_comb begin
      cur_trig  = trig_tab[cap_q];
      cur_pre   = pre_tab[cap_q];
      span      = cur_pre + cfg_post;
      off_last  = (off_q == span);
      cap_last  = (cap_q == cfg_seq_last);
      rd_finish = rd_go && off_last && cap_last;
      rd_bank   = cap_q;
      rd_addr   = cur_trig - cur_pre + off_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NCAP; i++) begin
            trig_tab[i] <= '0;
            pre_tab[i]  <= '0;
         end
      end else if (cap_done) begin
         trig_tab[cap_idx] <= cap_trig_addr;
         pre_tab[cap_idx]  <= cap_pre;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cap_q <= '0;
         off_q <= '0;
      end else if (rd_go) begin
         if (off_last) begin
            off_q <= '0;
            cap_q <= cap_last ? '0 : cap_q + SQW'(1);
         end else begin
            off_q <= off_q + AW'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_cap   <= '0;
         rd_pre   <= '0;
         rd_last  <= 1'b0;
      end else begin
         rd_valid <= rd_go;
         rd_cap   <= cap_q;
         rd_pre   <= cur_pre;
         rd_last  <= rd_finish;
      end
   end

   AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      rd_last |-> rd_valid); // R8
endmodule

// File: rtl/trace_window_seq.sv
module trace_window_seq
   import tws_pkg::*;
#(
   parameter int SAMPLE_W = 8,
   parameter int DEPTH    = 16,
   parameter int TRIG_LAT = 2,
   parameter int MAX_SEQ  = 4,
   localparam int AW  = $clog2(DEPTH),
   localparam int SQW = (MAX_SEQ > 1) ? $clog2(MAX_SEQ) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_start,
   input  logic                cmd_stop,
   input  logic [AW-1:0]       cfg_pre,
   input  logic [AW-1:0]       cfg_post,
   input  logic [SQW-1:0]      cfg_seq_last,
   input  logic                cfg_hold_en,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic                trig_in,
   input  logic                rd_en,
   output logic [2:0]          phase,
   output logic [SQW-1:0]      cap_idx,
   output logic                dut_hold,
   output logic                rd_valid,
   output logic [SAMPLE_W-1:0] rd_data,
   output logic [SQW-1:0]      rd_cap,
   output logic [AW-1:0]       rd_pre,
   output logic                rd_last
);
   localparam int MW = AW + SQW;

   generate
      if ((DEPTH < 2) || ((1 << AW) != DEPTH)) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if ((MAX_SEQ < 1) || ((MAX_SEQ > 1) && ((1 << SQW) != MAX_SEQ))) begin : g_bad_seq
         $error("MAX_SEQ must be a power of two");
      end
      if ((TRIG_LAT < 0) || (SAMPLE_W < 1)) begin : g_bad_misc
         $error("TRIG_LAT must be non-negative and SAMPLE_W positive");
      end
   endgenerate

   phase_e               ph;
   logic [SAMPLE_W-1:0]  smp_al;
   logic                 wr_en, cap_done, arm_clr, rd_go, rd_finish;
   logic [AW-1:0]        wr_ptr, cap_trig_addr, cap_pre, rd_addr;
   logic [SQW-1:0]       rd_bank;

   assign rd_go = rd_en && ((ph == PH_DONE) || (ph == PH_READ));
   assign phase = ph;

   tws_delay #(.W(SAMPLE_W), .LAT(TRIG_LAT)) u_align (
      .clk (clk),
      .d   (smp_data),
      .q   (smp_al)
   );

   tws_ctrl #(.AW(AW), .SQW(SQW)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start         (cmd_start),
      .stop          (cmd_stop),
      .trig          (trig_in),
      .cfg_pre       (cfg_pre),
      .cfg_post      (cfg_post),
      .cfg_seq_last  (cfg_seq_last),
      .cfg_hold_en   (cfg_hold_en),
      .rd_go         (rd_go),
      .rd_finish     (rd_finish),
      .ph            (ph),
      .wr_en         (wr_en),
      .wr_ptr        (wr_ptr),
      .cap_idx       (cap_idx),
      .cap_done      (cap_done),
      .cap_trig_addr (cap_trig_addr),
      .cap_pre       (cap_pre),
      .arm_clr       (arm_clr),
      .dut_hold      (dut_hold)
   );

   tws_mem #(.W(SAMPLE_W), .MW(MW)) u_mem (
      .clk   (clk),
      .we    (wr_en),
      .waddr ({cap_idx, wr_ptr}),
      .wdata (smp_al),
      .re    (rd_go),
      .raddr ({rd_bank, rd_addr}),
      .rdata (rd_data)
   );

   tws_reader #(.AW(AW), .SQW(SQW)) u_rd (
      .clk           (clk),
      .rst_n         (rst_n),
      .clr           (arm_clr),
      .cap_done      (cap_done),
      .cap_idx       (cap_idx),
      .cap_trig_addr (cap_trig_addr),
      .cap_pre       (cap_pre),
      .cfg_post      (cfg_post),
      .cfg_seq_last  (cfg_seq_last),
      .rd_go         (rd_go),
      .rd_finish     (rd_finish),
      .rd_bank       (rd_bank),
      .rd_addr       (rd_addr),
      .rd_valid      (rd_valid),
      .rd_cap        (rd_cap),
      .rd_pre        (rd_pre),
      .rd_last       (rd_last)
   );

   AST_RD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(ph) == PH_DONE || $past(ph) == PH_READ)); // R8
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_DONE) |=> (ph == PH_DONE || ph == PH_READ || ph == PH_IDLE)); // R8
endmodule

// File: tb/trace_window_seq_test.sv
`timescale 1ns/1ps
module trace_window_seq_test;
   localparam int LAT = 2;

   typedef struct {
      logic [7:0] d;
      int         cap;
      int         pre;
      bit         last;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_start = 1'b0, cmd_stop = 1'b0, cfg_hold_en = 1'b1;
   logic [3:0] cfg_pre = '0, cfg_post = '0;
   logic [1:0] cfg_seq_last = '0;
   logic       trig_in = 1'b0, rd_en = 1'b0;
   logic [7:0] smp_data;
   logic [2:0] phase;
   logic [1:0] cap_idx, rd_cap;
   logic       dut_hold, rd_valid, rd_last;
   logic [7:0] rd_data;
   logic [3:0] rd_pre;

   int ecnt = 0;
   int n_chk = 0, n_fail = 0, wd = 0;
   exp_t sb_q[$];

   always #4 clk = ~clk;
   always @(posedge clk) ecnt <= ecnt + 1;
   assign smp_data = ecnt[7:0];

   trace_window_seq uut (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
      .cfg_pre(cfg_pre), .cfg_post(cfg_post), .cfg_seq_last(cfg_seq_last),
      .cfg_hold_en(cfg_hold_en), .smp_data(smp_data), .trig_in(trig_in),
      .rd_en(rd_en), .phase(phase), .cap_idx(cap_idx), .dut_hold(dut_hold),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_cap(rd_cap), .rd_pre(rd_pre),
      .rd_last(rd_last)
   );

   task automatic check(string req, int act, int exp, string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // monitor: every read item is compared with the scoreboard head
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         n_chk++;
         if (sb_q.size() == 0) begin
            n_fail++;
            $display("FAIL R8 unexpected read item: actual %0d expected none", rd_data);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            if (rd_data !== e.d || int'(rd_cap) != e.cap || int'(rd_pre) != e.pre ||
                rd_last !== e.last) begin
               n_fail++;
               $display("FAIL R3/R8/R11 item: actual d=%0d cap=%0d pre=%0d last=%0b expected d=%0d cap=%0d pre=%0d last=%0b",
                        rd_data, rd_cap, rd_pre, rd_last, e.d, e.cap, e.pre, e.last);
            end
         end
      end
   end

   always @(posedge clk) begin
      wd++;
      if (wd > 100000) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   task automatic wait_edge(int n);
      while (ecnt < n) @(negedge clk);
   endtask

   task automatic do_start(output int s);
      @(negedge clk);
      s = ecnt;
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
   endtask

   task automatic fire(int t);
      wait_edge(t);
      trig_in = 1'b1;
      @(negedge clk);
      trig_in = 1'b0;
   endtask

   // driver side of the scoreboard: push one window in time order
   task automatic push_window(int v, int pre, int post, int cap, bit last_cap);
      for (int i = -pre; i <= post; i++) begin
         exp_t e;
         e.d = 8'(v + i);
         e.cap = cap;
         e.pre = pre;
         e.last = last_cap && (i == post);
         sb_q.push_back(e);
      end
   endtask

   task automatic drain();
      @(negedge clk);
      rd_en = 1'b1;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (phase == 3'd0) break;
      end
      rd_en = 1'b0;
      @(negedge clk);
      check("R8", sb_q.size(), 0, "items left unread");
      check("R8", phase, 0, "phase after readout");
   endtask

   initial begin
      int s, t, t1, t2, t3, seen;
      repeat (4) @(negedge clk);
      check("R1", phase, 0, "phase in reset");
      check("R1", dut_hold, 1, "hold in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", phase, 0, "phase after reset");
      check("R1", rd_valid, 0, "rd_valid after reset");
      // rd_en in idle has no effect
      rd_en = 1'b1;
      repeat (3) @(negedge clk);
      rd_en = 1'b0;
      check("R8", rd_valid, 0, "rd_valid with rd_en in idle");
      check("R10", dut_hold, 1, "hold before first start");

      // full-size window, trigger long after arming (wraps buffer)
      cfg_pre = 4'd10; cfg_post = 4'd5; cfg_seq_last = 2'd0;
      do_start(s);
      check("R2", phase, 1, "phase after start");
      check("R10", dut_hold, 0, "hold at start edge");
      wait_edge(s + 10);
      check("R4", phase, 1, "phase before pre full");
      wait_edge(s + 11);
      check("R4", phase, 2, "phase when pre full");
      t = s + 40;
      push_window(t - LAT, 10, 5, 0, 1'b1); // R9 R3
      fire(t);
      check("R6", phase, 3, "phase after trigger");
      wait_edge(t + 5);
      check("R6", phase, 3, "phase during post");
      wait_edge(t + 6);
      check("R8", phase, 4, "phase when done");
      drain();

      // early trigger keeps only what was stored
      cfg_pre = 4'd6; cfg_post = 4'd2;
      do_start(s);
      t = s + 3;
      push_window(t - LAT, 2, 2, 0, 1'b1); // R5
      fire(t);
      wait_edge(t + 3);
      check("R5", phase, 4, "phase after early capture");
      drain();

      // sequence of three captures, closely spaced
      cfg_pre = 4'd3; cfg_post = 4'd2; cfg_seq_last = 2'd2;
      do_start(s);
      t1 = s + 10;
      push_window(t1 - LAT, 3, 2, 0, 1'b0);
      fire(t1);
      fire(t1 + 1); // R6: ignored in post phase
      wait_edge(t1 + 3);
      check("R7", phase, 1, "re-armed phase");
      check("R7", cap_idx, 1, "capture index after re-arm");
      t2 = t1 + 3;
      push_window(t2 - LAT, 0, 2, 1, 1'b0);
      fire(t2);
      t3 = t2 + 2 + 8;
      push_window(t3 - LAT, 3, 2, 2, 1'b1);
      fire(t3);
      wait_edge(t3 + 3);
      check("R7", phase, 4, "done after sequence");
      check("R7", cap_idx, 2, "last capture index");
      drain();

      // stop discards the capture
      cfg_pre = 4'd4; cfg_post = 4'd3; cfg_seq_last = 2'd0;
      do_start(s);
      repeat (4) @(negedge clk);
      cmd_stop = 1'b1;
      @(negedge clk);
      cmd_stop = 1'b0;
      check("R2", phase, 0, "phase after stop");
      seen = 0;
      rd_en = 1'b1;
      repeat (4) begin
         @(negedge clk);
         if (rd_valid) seen++;
      end
      rd_en = 1'b0;
      check("R2", seen, 0, "reads after stop");

      // zero pre and zero post: single sample window
      cfg_pre = 4'd0; cfg_post = 4'd0;
      do_start(s);
      wait_edge(s + 2);
      check("R4", phase, 2, "waiting with zero pre");
      t = s + 6;
      push_window(t - LAT, 0, 0, 0, 1'b1);
      fire(t);
      check("R6", phase, 4, "done at trigger edge with zero post");
      drain();
      check("R10", dut_hold, 0, "hold stays released");

      summary();
   end
endmodule